// File: doc/BRIEF.md
# Byte-Lane DRAM Strobe Cycle Decoder

This block is a clocked front end for a sixteen-bit asynchronous page-mode DRAM interface. It is meant to sit behind the pins as a protocol checker or as a memory emulator. A sampling clock, at least four times faster than the shortest strobe pulse, captures the active-low row strobe, the two byte-lane column strobes, the write enable and the output enable. The block turns their edges into cycle decisions.

The two lane strobes are merged into one internal column strobe. The row and column addresses are latched, and each lane is classified as a read, an early write or a read-write. The block issues per-lane write pulses and a data-latch strobe, and produces per-lane output-enable controls for the shared data pins. Refresh cycles are recognised and reported: column-before-row and row-only. A small register file, indexed by the low bits of the latched row and column, stands in for the storage array. A sticky flag reports a column-strobe period in which one lane performed an early write and the other a late write.

Top module: `lane_dram_decoder`

## Requirements
- R1: `cas_int` goes high once either lane strobe is low, and returns low only after both lane strobes are high again.
- R2: Bit 0 of every lane vector belongs to `casl_n` and to data bits 7:0. Bit 1 belongs to `cash_n` and to data bits 15:8. A cycle with only one lane strobe low writes or drives only that byte and leaves the other byte of the word unchanged.
- R3: `row_addr` takes `addr` at the falling row strobe. `col_addr` takes `addr` at each first column-strobe fall while the row is open, so page mode sees a new column on each column strobe.
- R4: A write captures `dq_in` at the later of the write-enable fall and the lane-strobe fall. `data_stb` pulses once for each capture, and a later read of that cell returns the captured bytes.
- R5: A lane that is low with write enable high and output enable low has its `lane_oe` bit set, and drives the addressed cell's byte on `dq_out`.
- R6: A lane that falls while write enable is already low is an early write. Its `lane_oe` bit stays 0 until that lane strobe rises, even with output enable low.
- R7: When write enable falls after a lane entered a read, the lane becomes a read-write. Its `lane_oe` stays set and `dq_out` keeps the old cell data while the lane and output enable stay low, even when write enable stays low or the row strobe rises.
- R8: A row-strobe fall while a column strobe is already low pulses `cbr_ref` and starts no access. It sets no `lane_oe` and causes no write, and an ongoing read (hidden refresh) keeps driving.
- R9: A row strobe that falls and rises with no column strobe between them pulses `ras_ref` after the rise.
- R10: `mode_err` is set when, within one merged column-strobe low period, one lane made an early write and the other a late write. It stays set until the next first column-strobe fall. Early and late writes in separate periods do not set it.
- R11: After reset `cas_int`, `lane_oe`, `mode_err`, `row_addr` and `col_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-byte column strobe, active low |
| cash_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Data seen on the shared pins |
| row_addr | output | 10 | Latched row address |
| col_addr | output | 10 | Latched column address |
| cas_int | output | 1 | Merged internal column strobe, active high |
| lane_wr | output | 2 | Per-lane write pulse |
| data_stb | output | 1 | Data-latch strobe |
| wr_data | output | 16 | Captured write data |
| lane_oe | output | 2 | Per-lane drive enable for the data pins |
| dq_out | output | 16 | Read data for the pins |
| cbr_ref | output | 1 | Column-before-row refresh pulse |
| ras_ref | output | 1 | Row-only refresh pulse |
| mode_err | output | 1 | Mixed early/late write flag |

## Verification
A wrong lane mode shows up at the ports as a wrong `lane_oe` bit or as stale or fresh data on `dq_out`. A strobe change reaches the outputs within four sampling clocks: two synchroniser stages, the mode register and the output register. A wrong row or column latch shows up as wrong `row_addr`/`col_addr` and as wrong data on the next read-back. The bench therefore writes and reads every cell of the register file, and checks a few clocks after every strobe change. A misclassified refresh shows up as a missing or extra `cbr_ref`/`ras_ref` pulse, or as an unexpected write strobe.

// File: rtl/lane_dram_pkg.sv
package lane_dram_pkg;
  typedef enum logic [1:0] {
    LM_IDLE  = 2'd0,
    LM_READ  = 2'd1,
    LM_EARLY = 2'd2,
    LM_RW    = 2'd3
  } lane_mode_t;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_ROW  = 2'd1,
    RS_CBR  = 2'd2
  } row_state_t;
endpackage

// File: rtl/dram_pin_sync.sv
module dram_pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dram_lane_regfile.sv
module dram_lane_regfile #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int BW = DW / LANES;
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[waddr][l*BW +: BW] <= wdata[l*BW +: BW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import lane_dram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DW = 16,
  parameter int LANES = 2,
  parameter int RB = 2,
  parameter int CB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic [LANES-1:0]  lane_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DW-1:0]     dq_s,
  input  logic [DW-1:0]     mem_rdata,
  output logic [LANES-1:0]  mem_we,
  output logic [RB+CB-1:0]  mem_waddr,
  output logic [RB+CB-1:0]  mem_raddr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic              cas_int_q,
  output logic [LANES-1:0]  lane_wr_q,
  output logic              data_stb_q,
  output logic [DW-1:0]     wr_data_q,
  output logic [LANES-1:0]  lane_oe_q,
  output logic [DW-1:0]     dout_q,
  output logic              cbr_q,
  output logic              rasref_q,
  output logic              err_q
);
  localparam int BW = DW / LANES;

  // edge-detect history
  logic             ras_d, we_d;
  logic [LANES-1:0] lane_d;

  row_state_t st_q, st_nx;
  logic       seen_q, seen_nx;
  logic [ADDR_W-1:0] row_nx, col_nx;
  lane_mode_t mode_q [LANES];
  lane_mode_t mode_nx [LANES];
  logic [LANES-1:0] ew_q, ew_nx, lw_q, lw_nx;
  logic [LANES-1:0] oe_nx;
  logic [DW-1:0]    dout_nx;
  logic             cbr_nx, rasref_nx, err_nx, mixed;

  logic             ras_fall, ras_rise, we_fall;
  logic [LANES-1:0] lane_act, lane_fall;
  logic             cas_now, cas_prev, cas_fall, in_row;
  logic [LANES-1:0] early_go, read_go, rw_go, wr;
  logic [CB-1:0]    wcol;

  assign ras_fall  = ras_d & ~ras_s;
  assign ras_rise  = ~ras_d & ras_s;
  assign we_fall   = we_d & ~we_s;
  assign lane_act  = ~lane_s;
  assign lane_fall = lane_d & ~lane_s;
  assign cas_now   = |lane_act;
  assign cas_prev  = |(~lane_d);
  assign cas_fall  = cas_now & ~cas_prev;
  assign in_row    = (st_q == RS_ROW);

  // row / refresh sequencing
  always_comb begin
    st_nx     = st_q;
    seen_nx   = seen_q;
    row_nx    = row_q;
    col_nx    = col_q;
    cbr_nx    = 1'b0;
    rasref_nx = 1'b0;
    case (st_q)
      RS_IDLE: begin
        if (ras_fall) begin
          if (cas_prev) begin
            st_nx  = RS_CBR;
            cbr_nx = 1'b1;
          end else begin
            st_nx   = RS_ROW;
            row_nx  = addr_s;
            seen_nx = 1'b0;
          end
        end
      end
      RS_ROW: begin
        if (cas_fall) begin
          col_nx  = addr_s;
          seen_nx = 1'b1;
        end
        if (ras_rise) begin
          st_nx     = RS_IDLE;
          rasref_nx = ~seen_q & ~cas_fall;
        end
      end
      RS_CBR: begin
        if (ras_rise) st_nx = RS_IDLE;
      end
      default: st_nx = RS_IDLE;
    endcase
  end

  // per-lane mode decisions
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      early_go[l] = in_row & lane_fall[l] & ~we_s;
      read_go[l]  = in_row & lane_fall[l] & we_s;
      rw_go[l]    = in_row & lane_act[l] & ~lane_fall[l] &
                    (mode_q[l] == LM_READ) & we_fall;
      if (lane_s[l])        mode_nx[l] = LM_IDLE;
      else if (early_go[l]) mode_nx[l] = LM_EARLY;
      else if (read_go[l])  mode_nx[l] = LM_READ;
      else if (rw_go[l])    mode_nx[l] = LM_RW;
      else                  mode_nx[l] = mode_q[l];
      oe_nx[l] = lane_act[l] & ~oe_s &
                 (((mode_q[l] == LM_READ) & (we_s | rw_go[l])) |
                  (mode_q[l] == LM_RW));
      dout_nx[l*BW +: BW] = (mode_q[l] == LM_READ) ? mem_rdata[l*BW +: BW]
                                                   : dout_q[l*BW +: BW];
    end
    wr    = early_go | rw_go;
    ew_nx = (cas_fall ? '0 : ew_q) | early_go;
    lw_nx = (cas_fall ? '0 : lw_q) | rw_go;
    mixed = (ew_nx[0] & lw_nx[1]) | (lw_nx[0] & ew_nx[1]);
    err_nx = (cas_fall ? 1'b0 : err_q) | mixed;
  end

  assign wcol      = cas_fall ? addr_s[CB-1:0] : col_q[CB-1:0];
  assign mem_we    = wr;
  assign mem_waddr = {row_q[RB-1:0], wcol};
  assign mem_raddr = {row_q[RB-1:0], col_q[CB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d      <= 1'b1;
      we_d       <= 1'b1;
      lane_d     <= '1;
      st_q       <= RS_IDLE;
      seen_q     <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      for (int l = 0; l < LANES; l++) mode_q[l] <= LM_IDLE;
      ew_q       <= '0;
      lw_q       <= '0;
      err_q      <= 1'b0;
      cas_int_q  <= 1'b0;
      lane_wr_q  <= '0;
      data_stb_q <= 1'b0;
      wr_data_q  <= '0;
      lane_oe_q  <= '0;
      dout_q     <= '0;
      cbr_q      <= 1'b0;
      rasref_q   <= 1'b0;
    end else begin
      ras_d      <= ras_s;
      we_d       <= we_s;
      lane_d     <= lane_s;
      st_q       <= st_nx;
      seen_q     <= seen_nx;
      row_q      <= row_nx;
      col_q      <= col_nx;
      for (int l = 0; l < LANES; l++) mode_q[l] <= mode_nx[l];
      ew_q       <= ew_nx;
      lw_q       <= lw_nx;
      err_q      <= err_nx;
      cas_int_q  <= cas_now;
      lane_wr_q  <= wr;
      data_stb_q <= |wr;
      if (|wr) wr_data_q <= dq_s;
      lane_oe_q  <= oe_nx;
      dout_q     <= dout_nx;
      cbr_q      <= cbr_nx;
      rasref_q   <= rasref_nx;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R5: a lane is driven only if it was low with output enable low
    assert_oe_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_oe_q[g] |-> $past(!lane_s[g] && !oe_s));
    // R6: an early-write lane never drives
    assert_early_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[g] == LM_EARLY) |=> !lane_oe_q[g]);
  end

  // R8: refresh pulses never coincide with a data capture
  assert_refresh_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cbr_q, rasref_q, data_stb_q}));

  // R10: the mixed-mode flag only rises right after a write decision
  assert_err_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(|wr));
endmodule

// File: rtl/lane_dram_decoder.sv
module lane_dram_decoder #(
  parameter int ADDR_W = 10,
  parameter int DW = 16,
  parameter int BYTE_W = 8,
  parameter int MEM_ROW_BITS = 2,
  parameter int MEM_COL_BITS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              casl_n,
  input  logic              cash_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic              cas_int,
  output logic [1:0]        lane_wr,
  output logic              data_stb,
  output logic [DW-1:0]     wr_data,
  output logic [1:0]        lane_oe,
  output logic [DW-1:0]     dq_out,
  output logic              cbr_ref,
  output logic              ras_ref,
  output logic              mode_err
);
  localparam int LANES = DW / BYTE_W;
  localparam int CTL_W = LANES + 3;
  localparam int DAT_W = ADDR_W + DW;
  localparam int MAW   = MEM_ROW_BITS + MEM_COL_BITS;

  logic [CTL_W-1:0] ctl_s;
  logic [DAT_W-1:0] dat_s;
  logic [MAW-1:0]   waddr, raddr;
  logic [LANES-1:0] mem_we;
  logic [DW-1:0]    rdata;

  dram_pin_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ras_n, cash_n, casl_n, we_n, oe_n}),
    .q(ctl_s)
  );

  dram_pin_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL({DAT_W{1'b0}})) u_dat_sync (
    .clk(clk), .rst_n(rst_n),
    .d({addr, dq_in}),
    .q(dat_s)
  );

  dram_cycle_ctrl #(
    .ADDR_W(ADDR_W), .DW(DW), .LANES(LANES), .RB(MEM_ROW_BITS), .CB(MEM_COL_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ras_s(ctl_s[CTL_W-1]),
    .lane_s(ctl_s[CTL_W-2:2]),
    .we_s(ctl_s[1]),
    .oe_s(ctl_s[0]),
    .addr_s(dat_s[DAT_W-1:DW]),
    .dq_s(dat_s[DW-1:0]),
    .mem_rdata(rdata),
    .mem_we(mem_we),
    .mem_waddr(waddr),
    .mem_raddr(raddr),
    .row_q(row_addr),
    .col_q(col_addr),
    .cas_int_q(cas_int),
    .lane_wr_q(lane_wr),
    .data_stb_q(data_stb),
    .wr_data_q(wr_data),
    .lane_oe_q(lane_oe),
    .dout_q(dq_out),
    .cbr_q(cbr_ref),
    .rasref_q(ras_ref),
    .err_q(mode_err)
  );

  dram_lane_regfile #(.AW(MAW), .DW(DW), .LANES(LANES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(dat_s[DW-1:0]),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/lane_dram_decoder_bench.sv
module lane_dram_decoder_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ras_n, casl_n, cash_n, we_n, oe_n;
  logic [9:0]  addr;
  logic [15:0] dq_in;
  logic [9:0]  row_addr, col_addr;
  logic        cas_int, data_stb, cbr_ref, ras_ref, mode_err;
  logic [1:0]  lane_wr, lane_oe;
  logic [15:0] wr_data, dq_out;

  int errors = 0;
  int checks = 0;
  int cnt_stb = 0, cnt_cbr = 0, cnt_rref = 0;
  bit done = 1'b0;
  logic [15:0] model [16];

  always #2.5 clk = ~clk;

  lane_dram_decoder u_lane_dram_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .row_addr(row_addr), .col_addr(col_addr), .cas_int(cas_int),
    .lane_wr(lane_wr), .data_stb(data_stb), .wr_data(wr_data),
    .lane_oe(lane_oe), .dq_out(dq_out), .cbr_ref(cbr_ref),
    .ras_ref(ras_ref), .mode_err(mode_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_stb) cnt_stb++;
      if (cbr_ref)  cnt_cbr++;
      if (ras_ref)  cnt_rref++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rowv(input int r);
    return 10'h2C0 | 10'(r);
  endfunction
  function automatic logic [9:0] colv(input int c);
    return 10'h150 | 10'(c);
  endfunction
  function automatic logic [15:0] lmask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // early write: WE low before the lane strobes fall
  task automatic wr_word(input int r, input int c, input logic [15:0] d, input logic [1:0] m);
    addr = rowv(r); ras_n = 1'b0; step(4);
    addr = colv(c); dq_in = d; we_n = 1'b0; step(3);
    casl_n = ~m[0]; cash_n = ~m[1]; step(6);
    chk(lane_oe == 2'b00, "R6 early write drives", 32'(lane_oe), 0);
    casl_n = 1'b1; cash_n = 1'b1; step(3);
    we_n = 1'b1; ras_n = 1'b1; step(5);
    model[r*4+c] = (model[r*4+c] & ~lmask(m)) | (d & lmask(m));
  endtask

  task automatic rd_check(input int r, input int c, input logic [1:0] m);
    addr = rowv(r); ras_n = 1'b0; step(4);
    addr = colv(c); step(2);
    casl_n = ~m[0]; cash_n = ~m[1]; step(6);
    chk(lane_oe == m, "R5/R2 lane drive", 32'(lane_oe), 32'(m));
    chk((dq_out & lmask(m)) == (model[r*4+c] & lmask(m)), "R5/R4 read data",
        32'(dq_out & lmask(m)), 32'(model[r*4+c] & lmask(m)));
    chk(row_addr == rowv(r) && col_addr == colv(c), "R3 address latch",
        {6'd0, row_addr, col_addr}, {6'd0, rowv(r), colv(c)});
    casl_n = 1'b1; cash_n = 1'b1; step(3);
    ras_n = 1'b1; step(5);
  endtask

  initial begin
    int s0, c0;
    logic [15:0] old_d;
    rst_n = 1'b0; ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1;
    we_n = 1'b1; oe_n = 1'b0; addr = '0; dq_in = '0;
    step(4);
    chk(cas_int == 1'b0 && lane_oe == 2'b00 && mode_err == 1'b0, "R11 reset outputs",
        {29'd0, cas_int, lane_oe}, 0);
    chk(row_addr == 10'd0 && col_addr == 10'd0, "R11 reset addresses",
        {row_addr, col_addr}, 0);
    rst_n = 1'b1; step(3);

    // R1: merged strobe, first low / last high
    casl_n = 1'b0; step(4);
    chk(cas_int == 1'b1, "R1 first lane low", 32'(cas_int), 1);
    cash_n = 1'b0; step(2); casl_n = 1'b1; step(4);
    chk(cas_int == 1'b1, "R1 one lane still low", 32'(cas_int), 1);
    cash_n = 1'b1; step(4);
    chk(cas_int == 1'b0, "R1 both lanes high", 32'(cas_int), 0);

    // R4: one strobe per word capture
    s0 = cnt_stb;
    wr_word(0, 0, 16'hBEEF, 2'b11);
    chk(cnt_stb == s0 + 1, "R4 data strobe count", 32'(cnt_stb - s0), 1);
    chk(wr_data == 16'hBEEF, "R4 captured data", 32'(wr_data), 32'hBEEF);

    // fill every cell, then read every cell back
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        wr_word(r, c, {4'(r), 4'(c), ~4'(r), ~4'(c)} ^ 16'h5A00, 2'b11);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        rd_check(r, c, 2'b11);

    // R2: byte lanes
    wr_word(1, 2, 16'hC33C, 2'b01);
    rd_check(1, 2, 2'b01);
    rd_check(1, 2, 2'b11);
    wr_word(2, 3, 16'h7EE7, 2'b10);
    rd_check(2, 3, 2'b10);
    rd_check(2, 3, 2'b11);

    // R3: page mode over one open row
    addr = rowv(2); ras_n = 1'b0; step(4);
    for (int c = 0; c < 4; c++) begin
      addr = colv(c); step(2);
      casl_n = 1'b0; cash_n = 1'b0; step(6);
      chk(col_addr == colv(c), "R3 page column", 32'(col_addr), 32'(colv(c)));
      chk(dq_out == model[8+c] && lane_oe == 2'b11, "R3 page data",
          32'(dq_out), 32'(model[8+c]));
      casl_n = 1'b1; cash_n = 1'b1; step(4);
    end
    ras_n = 1'b1; step(5);

    // R7: read-write keeps old data driven
    old_d = model[13];
    s0 = cnt_stb;
    addr = rowv(3); ras_n = 1'b0; step(4);
    addr = colv(1); step(2);
    casl_n = 1'b0; cash_n = 1'b0; step(6);
    dq_in = 16'h1234; we_n = 1'b0; step(6);
    chk(lane_oe == 2'b11, "R7 drive after late write", 32'(lane_oe), 3);
    chk(dq_out == old_d, "R7 old data held", 32'(dq_out), 32'(old_d));
    ras_n = 1'b1; step(6);
    chk(lane_oe == 2'b11 && dq_out == old_d, "R7 drive after row rise",
        {14'd0, lane_oe, dq_out}, {14'd0, 2'b11, old_d});
    casl_n = 1'b1; cash_n = 1'b1; step(3); we_n = 1'b1; step(5);
    chk(cnt_stb == s0 + 1, "R4 late capture strobe", 32'(cnt_stb - s0), 1);
    model[13] = 16'h1234;
    rd_check(3, 1, 2'b11);

    // R6: next access after an early write drives again
    wr_word(0, 1, 16'h0F0F, 2'b11);
    rd_check(0, 1, 2'b11);

    // R8: column-before-row refresh
    c0 = cnt_cbr; s0 = cnt_stb;
    casl_n = 1'b0; cash_n = 1'b0; step(4);
    ras_n = 1'b0; step(6);
    chk(cnt_cbr == c0 + 1, "R8 refresh pulse", 32'(cnt_cbr - c0), 1);
    chk(lane_oe == 2'b00, "R8 no drive in refresh", 32'(lane_oe), 0);
    ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1; step(5);
    chk(cnt_stb == s0, "R8 no write in refresh", 32'(cnt_stb - s0), 0);

    // R8: hidden refresh during a read
    c0 = cnt_cbr;
    addr = rowv(0); ras_n = 1'b0; step(4);
    addr = colv(1); step(2);
    casl_n = 1'b0; cash_n = 1'b0; step(6);
    ras_n = 1'b1; step(4); ras_n = 1'b0; step(6);
    chk(cnt_cbr == c0 + 1, "R8 hidden refresh pulse", 32'(cnt_cbr - c0), 1);
    chk(lane_oe == 2'b11 && dq_out == model[1], "R8 hidden refresh keeps data",
        32'(dq_out), 32'(model[1]));
    ras_n = 1'b1; step(2); casl_n = 1'b1; cash_n = 1'b1; step(5);

    // R9: row-only refresh
    c0 = cnt_rref;
    addr = 10'h3FF; ras_n = 1'b0; step(4);
    ras_n = 1'b1; step(5);
    chk(cnt_rref == c0 + 1, "R9 row-only pulse", 32'(cnt_rref - c0), 1);
    chk(row_addr == 10'h3FF, "R3 row latch in refresh", 32'(row_addr), 32'h3FF);

    // R10: mixed early/late in one period
    addr = rowv(0); ras_n = 1'b0; step(4);
    addr = colv(2); dq_in = 16'hA55A; we_n = 1'b0; step(3);
    casl_n = 1'b0; step(4);
    we_n = 1'b1; step(3);
    cash_n = 1'b0; step(4);
    we_n = 1'b0; step(6);
    chk(mode_err == 1'b1, "R10 mixed flag set", 32'(mode_err), 1);
    casl_n = 1'b1; cash_n = 1'b1; step(2); we_n = 1'b1; step(4);
    chk(mode_err == 1'b1, "R10 flag sticky", 32'(mode_err), 1);
    ras_n = 1'b1; step(5);
    model[2] = 16'hA55A;
    wr_word(0, 3, 16'h6996, 2'b11);
    chk(mode_err == 1'b0, "R10 cleared next period", 32'(mode_err), 0);

    // R10: early then late across a precharge is allowed
    addr = rowv(1); ras_n = 1'b0; step(4);
    addr = colv(0); dq_in = 16'h1111; we_n = 1'b0; step(3);
    casl_n = 1'b0; step(6); casl_n = 1'b1; step(2); we_n = 1'b1; step(4);
    cash_n = 1'b0; step(4); dq_in = 16'h2222; we_n = 1'b0; step(6);
    chk(mode_err == 1'b0, "R10 separate periods", 32'(mode_err), 0);
    cash_n = 1'b1; step(2); we_n = 1'b1; ras_n = 1'b1; step(5);
    model[4] = 16'h2211;
    rd_check(1, 0, 2'b11);
    rd_check(0, 2, 2'b11);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule